// File: doc/BRIEF.md
# Dual-Channel Split-Phase PWM Generator

This block produces two independent pulse-width-modulated outputs. Each channel's waveform is described by two 16-bit counts rather than a period and a compare value. One count sets how many prescaled ticks the output spends high. The other sets how many ticks it then spends low. The pattern repeats for as long as the channel runs. A single control word, shared by both channels, gives each channel a choice of one of four tick sources, a 7-bit divider, a counting gate and an output enable.

All logic runs on one system clock. The four tick sources arrive as single-cycle enable strobes. A simple word-addressed read/write bus reaches the three registers: one count register per channel and the shared control word. Each channel has a prescaler that divides its selected strobe. That prescaler feeds a three-state phase machine. The machine has the states PH_IDLE, PH_HIGH and PH_LOW, and its transitions are:
- PH_IDLE to PH_HIGH on enable when the high count is nonzero, and to PH_LOW otherwise.
- PH_HIGH to PH_LOW on the last high tick.
- PH_LOW back to PH_HIGH (or to PH_LOW when the high count is zero) on the last low tick. This is the period boundary, where new counts are loaded.
- Any state to PH_IDLE as soon as the enable clears.

Top module: `dual_pwm_gen`

## Requirements
- R1: After reset, every register reads zero and both outputs are low.
- R2: The byte offsets are 0x0 for the channel A count register, 0x4 for the channel B count register and 0x8 for the control word. A read returns the last value written to that register. Any other offset reads zero, and a write to it changes nothing.
- R3: In a count register, bits 31:16 give the high-phase tick count and bits 15:0 give the low-phase tick count. A running channel is high for the high count of ticks, then low for the low count of ticks, and then repeats.
- R4: In the control word, channel A uses bit 0 as enable, bits 5:4 as source select, bits 14:8 as divider and bit 15 as gate. Channel B uses bit 1, bits 7:6, bits 22:16 and bit 23 for the same fields.
- R5: A divider value N produces one tick for every N+1 strobes of the selected source. The output changes only on a tick, and never while the channel stays enabled with no tick.
- R6: Source select value k picks strobe input k. In the bench, strobe k pulses once every k+1 clocks.
- R7: A low count of zero still gives one low tick per period.
- R8: A high count of zero keeps the output low throughout.
- R9: A high count of 0xFFFF with a low count of 0 gives 65535 high ticks followed by exactly one low tick.
- R10: Clearing a channel's enable drives its output low in the first cycle after the write, without finishing the current period.
- R11: A channel counts ticks only while both its enable and its gate are set. With the gate clear, the output holds its level.
- R12: Counts written while a channel runs take effect at the next period boundary. A rising enable starts the period in the high phase on the following cycle.
- R13: Channel B runs from its own fields, independently of channel A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_tick | input | 4 | Clock-enable strobes of the four tick sources |
| pwm_out | output | 2 | PWM outputs; bit 0 is channel A, bit 1 is channel B |

## Verification
The steady-state high and low widths are measured over a period that follows the first one. This removes the phase offset between enable and the first strobe. The patterns tried are symmetric and asymmetric counts, a divided tick, each slower strobe source, and a zero low count. Together they separate a swapped count field, an off-by-one in the divider and a wrong source index. Directed cases cover the remaining behaviour:
- a zero high count;
- the all-high/zero-low extreme;
- a mid-period disable;
- a cleared gate;
- a count rewrite in the middle of a high phase, which shows whether the new values wait for the period boundary.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int NCH       = 2;
    localparam int REG_W     = 32;
    localparam int HI_LSB    = 16;
    localparam int LO_LSB    = 0;
    localparam int SEL_LSB   = 4;
    localparam int SEL_STEP  = 2;
    localparam int DIV_LSB   = 8;
    localparam int DIV_STEP  = 8;
    localparam int GATE_LSB  = 15;
    localparam logic [3:0] CTRL_ADDR = 4'h8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;
endpackage

// File: rtl/pwm_regbank.sv
module pwm_regbank
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 7,
    parameter int SEL_W = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [3:0]                      addr,
    input  logic [REG_W-1:0]                wdata,
    output logic [REG_W-1:0]                rdata,
    output logic [NCH-1:0][CNT_W-1:0]       hi_cnt,
    output logic [NCH-1:0][CNT_W-1:0]       lo_cnt,
    output logic [NCH-1:0]                  en,
    output logic [NCH-1:0]                  gate,
    output logic [NCH-1:0][SEL_W-1:0]       sel,
    output logic [NCH-1:0][DIV_W-1:0]       div
);
    logic [NCH-1:0][REG_W-1:0] cnt_q;
    logic [REG_W-1:0]          ctrl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            ctrl_q <= '0;
        end else if (we) begin
            for (int c = 0; c < NCH; c++) begin
                if (addr == 4'(c * 4)) cnt_q[c] <= wdata;
            end
            if (addr == CTRL_ADDR) ctrl_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (addr == 4'(c * 4)) rdata = cnt_q[c];
        end
        if (addr == CTRL_ADDR) rdata = ctrl_q;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_fields
        assign hi_cnt[c] = cnt_q[c][HI_LSB +: CNT_W];
        assign lo_cnt[c] = cnt_q[c][LO_LSB +: CNT_W];
        assign en[c]     = ctrl_q[c];
        assign sel[c]    = ctrl_q[SEL_LSB + SEL_STEP * c +: SEL_W];
        assign div[c]    = ctrl_q[DIV_LSB + DIV_STEP * c +: DIV_W];
        assign gate[c]   = ctrl_q[GATE_LSB + DIV_STEP * c];
    end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int DIV_W = 7,
    parameter int N_SRC = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    input  logic [DIV_W-1:0] div,
    input  logic [N_SRC-1:0] src_tick,
    output logic             tick
);
    logic [DIV_W-1:0] pcnt_q;
    logic             strobe;
    logic             wrap;

    assign strobe = src_tick[sel];
    assign wrap   = (pcnt_q >= div);
    assign tick   = run && strobe && wrap;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pcnt_q <= '0;
        end else if (strobe) begin
            pcnt_q <= wrap ? '0 : pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_phase_fsm.sv
module pwm_phase_fsm
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] hi_in,
    input  logic [CNT_W-1:0] lo_in,
    output logic             pwm,
    output logic             active
);
    phase_e           state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [CNT_W-1:0] hi_q, hi_n;
    logic [CNT_W-1:0] lo_q, lo_n;
    logic             last_high, last_low;

    assign last_high = (cnt_q == hi_q - CNT_W'(1));
    assign last_low  = (lo_q == '0) || (cnt_q == lo_q - CNT_W'(1));

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        hi_n    = hi_q;
        lo_n    = lo_q;
        unique case (state_q)
            PH_IDLE: begin
                if (en) begin
                    hi_n    = hi_in;
                    lo_n    = lo_in;
                    cnt_n   = '0;
                    state_n = (hi_in == '0) ? PH_LOW : PH_HIGH;
                end
            end
            PH_HIGH: begin
                if (!en) begin
                    state_n = PH_IDLE;
                end else if (tick) begin
                    if (last_high) begin
                        cnt_n   = '0;
                        state_n = PH_LOW;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            PH_LOW: begin
                if (!en) begin
                    state_n = PH_IDLE;
                end else if (tick) begin
                    if (last_low) begin
                        hi_n    = hi_in;
                        lo_n    = lo_in;
                        cnt_n   = '0;
                        state_n = (hi_in == '0) ? PH_LOW : PH_HIGH;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            default: state_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            hi_q    <= hi_n;
            lo_q    <= lo_n;
        end
    end

    always_comb begin
        pwm    = (state_q == PH_HIGH) && en;
        active = (state_q != PH_IDLE);
    end
endmodule

// File: rtl/dual_pwm_gen.sv
module dual_pwm_gen
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 7,
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [3:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [N_SRC-1:0] src_tick,
    output logic [NCH-1:0]   pwm_out
);
    localparam int SEL_W = $clog2(N_SRC);

    logic [NCH-1:0][CNT_W-1:0] ch_hi, ch_lo;
    logic [NCH-1:0]            ch_en, ch_gate, ch_tick, ch_active;
    logic [NCH-1:0][SEL_W-1:0] ch_sel;
    logic [NCH-1:0][DIV_W-1:0] ch_div;

    pwm_regbank #(.CNT_W(CNT_W), .DIV_W(DIV_W), .SEL_W(SEL_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .hi_cnt (ch_hi),
        .lo_cnt (ch_lo),
        .en     (ch_en),
        .gate   (ch_gate),
        .sel    (ch_sel),
        .div    (ch_div)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm_prescaler #(.DIV_W(DIV_W), .N_SRC(N_SRC), .SEL_W(SEL_W)) u_pre (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (ch_gate[c] && ch_active[c] && ch_en[c]),
            .sel      (ch_sel[c]),
            .div      (ch_div[c]),
            .src_tick (src_tick),
            .tick     (ch_tick[c])
        );

        pwm_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (ch_en[c]),
            .tick   (ch_tick[c]),
            .hi_in  (ch_hi[c]),
            .lo_in  (ch_lo[c]),
            .pwm    (pwm_out[c]),
            .active (ch_active[c])
        );
    end
endmodule

// File: rtl/pwm_checker.sv
module pwm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_we,
    input logic [3:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [1:0]  pwm_out,
    input logic [1:0]  en,
    input logic [1:0]  gate,
    input logic [1:0]  tick,
    input logic [1:0]  active
);
    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != 4'h0 && bus_addr != 4'h4 && bus_addr != 4'h8) |-> bus_rdata == 32'h0);

    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_we && bus_addr == 4'h0) && bus_addr == 4'h0) |-> bus_rdata == $past(bus_wdata));

    for (genvar c = 0; c < 2; c++) begin : g_chk
        p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !en[c] |=> !active[c]);

        p_gate_needed_r11: assert property (@(posedge clk) disable iff (!rst_n)
            tick[c] |-> (gate[c] && en[c]));

        p_change_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(en[c]) && en[c] && $past(active[c]) && !$past(tick[c]))
                |-> pwm_out[c] == $past(pwm_out[c]));
    end
endmodule

bind dual_pwm_gen pwm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .en        (ch_en),
    .gate      (ch_gate),
    .tick      (ch_tick),
    .active    (ch_active)
);

// File: tb/dual_pwm_gen_test.sv
module dual_pwm_gen_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_we;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [3:0]  src_tick;
    logic [1:0]  pwm_out;

    int n_checks = 0;
    int n_fail   = 0;
    int phase_ctr = 0;

    always #10 clk = ~clk;

    dual_pwm_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_tick  (src_tick),
        .pwm_out   (pwm_out)
    );

    // {channel, high, low, divider, select, expected high clocks, expected low clocks}
    localparam int VEC[7][7] = '{
        '{0, 3, 2, 0, 0,  3,  2},
        '{0, 1, 1, 0, 0,  1,  1},
        '{0, 2, 4, 2, 0,  6, 12},
        '{0, 2, 3, 0, 1,  4,  6},
        '{0, 4, 0, 0, 0,  4,  1},
        '{0, 2, 1, 1, 3, 16,  8},
        '{1, 3, 3, 0, 2,  9,  9}
    };

    // strobe k pulses once every k+1 clocks
    initial begin
        src_tick = '0;
        forever begin
            @(negedge clk);
            phase_ctr++;
            for (int k = 0; k < 4; k++) src_tick[k] = ((phase_ctr % (k + 1)) == 0);
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_level(input int ch, input logic lvl, input int limit, output int n);
        n = 0;
        while (pwm_out[ch] != lvl && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic logic [31:0] ctrl_word(input int ch, input logic en, input int sel,
                                              input int dv, input logic gate);
        logic [31:0] w = '0;
        w[ch]            = en;
        w[4 + 2*ch +: 2] = sel[1:0];
        w[8 + 8*ch +: 7] = dv[6:0];
        w[15 + 8*ch]     = gate;
        return w;
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=190000 cycles expected=fewer");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        int n, hi_len, lo_len, toggles;
        logic prev;

        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(4'h0, rd); check("R1 count A reset", rd, 0);
        bus_read(4'h4, rd); check("R1 count B reset", rd, 0);
        bus_read(4'h8, rd); check("R1 control reset", rd, 0);
        check("R1 outputs low", pwm_out, 0);

        // R2 map and readback
        bus_write(4'h0, 32'h1234_5678); bus_read(4'h0, rd); check("R2 readback A", rd, 32'h1234_5678);
        bus_write(4'h4, 32'h9ABC_DEF0); bus_read(4'h4, rd); check("R2 readback B", rd, 32'h9ABC_DEF0);
        bus_write(4'h8, 32'hFF00_000C); bus_read(4'h8, rd); check("R2 readback ctrl", rd, 32'hFF00_000C);
        bus_write(4'hC, 32'hFFFF_FFFF); bus_read(4'hC, rd); check("R2 unmapped reads zero", rd, 0);
        bus_read(4'h2, rd); check("R2 misaligned reads zero", rd, 0);
        bus_read(4'h0, rd); check("R2 unmapped write ignored", rd, 32'h1234_5678);
        bus_write(4'h8, 32'h0);

        // R3 R4 R5 R6 R7 R13 vector table
        for (int v = 0; v < 7; v++) begin
            int ch;
            ch = VEC[v][0];
            bus_write(4'h8, 32'h0);
            bus_write(4'(ch * 4), {16'(VEC[v][1]), 16'(VEC[v][2])});
            bus_write(4'h8, ctrl_word(ch, 1'b1, VEC[v][4], VEC[v][3], 1'b1));
            wait_level(ch, 1'b1, 2000, n);
            wait_level(ch, 1'b0, 2000, n);
            wait_level(ch, 1'b1, 2000, lo_len);
            wait_level(ch, 1'b0, 2000, hi_len);
            check($sformatf("R3 R5 R6 R7 R13 vector %0d high clocks", v), hi_len, VEC[v][5]);
            check($sformatf("R3 R5 R6 R7 R13 vector %0d low clocks", v), lo_len, VEC[v][6]);
        end
        bus_write(4'h8, 32'h0);

        // R8 zero high count
        bus_write(4'h0, {16'd0, 16'd3});
        bus_write(4'h8, ctrl_word(0, 1'b1, 0, 0, 1'b1));
        n = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (pwm_out[0]) n++; end
        check("R8 zero high stays low", n, 0);
        bus_write(4'h8, 32'h0);

        // R10 immediate disable
        bus_write(4'h0, {16'd20, 16'd20});
        bus_write(4'h8, ctrl_word(0, 1'b1, 0, 0, 1'b1));
        wait_level(0, 1'b1, 100, n);
        @(negedge clk);
        bus_write(4'h8, ctrl_word(0, 1'b0, 0, 0, 1'b1));
        check("R10 low right after disable", pwm_out[0], 0);
        n = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (pwm_out[0]) n++; end
        check("R10 stays low while disabled", n, 0);

        // R12 rising enable starts high
        bus_write(4'h0, {16'd5, 16'd5});
        bus_write(4'h8, ctrl_word(0, 1'b1, 0, 0, 1'b1));
        check("R12 still low in write cycle", pwm_out[0], 0);
        @(negedge clk);
        check("R12 high on cycle after enable", pwm_out[0], 1);
        bus_write(4'h8, 32'h0);

        // R11 gate
        bus_write(4'h0, {16'd1, 16'd1});
        bus_write(4'h8, ctrl_word(0, 1'b1, 0, 0, 1'b0));
        repeat (2) @(negedge clk);
        prev = pwm_out[0]; toggles = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); if (pwm_out[0] != prev) toggles++; prev = pwm_out[0];
        end
        check("R11 no toggles with gate clear", toggles, 0);
        bus_write(4'h8, ctrl_word(0, 1'b1, 0, 0, 1'b1));
        prev = pwm_out[0]; toggles = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); if (pwm_out[0] != prev) toggles++; prev = pwm_out[0];
        end
        check("R11 toggles once gate set", toggles > 0, 1);
        bus_write(4'h8, 32'h0);

        // R12 count update waits for period boundary
        bus_write(4'h0, {16'd4, 16'd4});
        bus_write(4'h8, ctrl_word(0, 1'b1, 0, 0, 1'b1));
        wait_level(0, 1'b1, 100, n);
        wait_level(0, 1'b0, 100, n);
        wait_level(0, 1'b1, 100, n);
        bus_write(4'h0, {16'd2, 16'd2});
        wait_level(0, 1'b0, 100, n);
        check("R12 current high phase keeps old count", n + 2, 4);
        wait_level(0, 1'b1, 100, lo_len);
        check("R12 current low phase keeps old count", lo_len, 4);
        wait_level(0, 1'b0, 100, hi_len);
        check("R12 next period uses new count", hi_len, 2);
        bus_write(4'h8, 32'h0);

        // R9 full high with zero low
        bus_write(4'h0, {16'hFFFF, 16'h0000});
        bus_write(4'h8, ctrl_word(0, 1'b1, 0, 0, 1'b1));
        wait_level(0, 1'b1, 100, n);
        wait_level(0, 1'b0, 70000, hi_len);
        wait_level(0, 1'b1, 100, lo_len);
        check("R9 high clocks", hi_len, 65535);
        check("R9 single low tick", lo_len, 1);
        bus_write(4'h8, 32'h0);

        finish_run();
    end
endmodule